// File: doc/BRIEF.md
# Microsecond Timebase with Fractional Prescaler

This block derives an average 1 MHz tick from a reference clock. The reference can run at any of several oscillator rates, including rates that are not a whole multiple of 1 MHz such as 19.2 MHz or 38.4 MHz. A programmable fractional prescaler produces D ticks for every V reference cycles. It spreads the ticks evenly inside each V-cycle window by means of an accumulator. Each tick is a one-cycle pulse in the reference clock domain and drives the interval timers.

The same ticks advance a free-running microsecond counter. The counter wraps modulo 2^COUNT_W and can be held by a freeze control. A small register port writes and reads the 16-bit prescaler word, reads the counter, and sets or clears the freeze. Software can read the prescaler word, keep it, and later write it back to restore the same tick behaviour.

Top module: `usec_timebase`

## Requirements
- R1: After reset the counter reads 0, the prescaler word reads 0x000B, freeze reads 0 and tick_o is low. The reset word yields exactly 10 ticks in any 120 consecutive cycles.
- R2: The prescaler word holds D-1 in bits 15:8 and V-1 in bits 7:0. For D < V, counting edges from the word's write edge, tick_o is high after the n-th following edge exactly when floor(n*D/V) > floor((n-1)*D/V).
- R3: When D >= V, tick_o is high after every edge that follows the write edge.
- R4: The counter rises by one for each tick while not frozen, and it wraps modulo 2^COUNT_W.
- R5: Bit 0 of the freeze register is the freeze control. While it is 1 the counter holds its value and ticks continue. It takes effect from the edge after the write.
- R6: A written prescaler word reads back unchanged, with zeros above bit 15. Writing the read-back value again restores the same tick pattern.
- R7: A write to the prescaler word clears the accumulator and suppresses the tick at the write edge. A write to the counter address changes nothing.
- R8: The register addresses are 0 for the counter (read-only), 1 for the prescaler word and 2 for freeze. Address 3 reads zero. Read data is combinational from the address.
- R9: The words 0x000B, 0x000C, 0x0453, 0x045F, 0x04BF, 0x0019 and 0x002F each give exactly 2*D ticks in 2*V cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | RD_W (max of COUNT_W and 16) | Register read data |
| tick_o | output | 1 | One-cycle microsecond tick |

## Verification
A prescaler word written at edge E clears the accumulator at E. The first accumulation happens at E+1, and both tick_o and the counter change at that same edge. A freeze write affects the counter from E+1 onward. Read data is combinational. The bench drives inputs on falling edges and samples tick_o once per following falling edge, which lines sample n up with edge E+n in the R2 formula. It reads registers one nanosecond after a falling edge, so no read coincides with a rising edge. A near-exhaustive sweep over dividends 1 to 8 and divisors 1 to 24 checks the exact per-cycle pattern and the counter delta for each word.

// File: rtl/usec_pkg.sv
package usec_pkg;
  localparam int FIELD_W = 8;
  localparam int CFG_W   = 2 * FIELD_W;

  typedef struct packed {
    logic [FIELD_W-1:0] mul_m1;
    logic [FIELD_W-1:0] div_m1;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{mul_m1: 8'h00, div_m1: 8'h0B};

  typedef enum logic [1:0] {
    ADDR_COUNT  = 2'd0,
    ADDR_CFG    = 2'd1,
    ADDR_FREEZE = 2'd2,
    ADDR_SPARE  = 2'd3
  } addr_e;
endpackage

// File: rtl/usec_rst_sync.sv
module usec_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/usec_regs.sv
module usec_regs
  import usec_pkg::*;
#(
  parameter int COUNT_W = 32,
  parameter int RD_W    = 32
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [1:0]         addr_i,
  input  logic [CFG_W-1:0]   wdata_i,
  input  logic [COUNT_W-1:0] count_i,
  output cfg_t               cfg_o,
  output logic               freeze_o,
  output logic               cfg_wr_o,
  output logic [RD_W-1:0]    rdata_o
);
  cfg_t  cfg_q, cfg_d;
  logic  freeze_q, freeze_d;
  logic  cfg_en, frz_en;
  addr_e addr;

  assign addr   = addr_e'(addr_i);
  assign cfg_en = wr_i && (addr == ADDR_CFG);
  assign frz_en = wr_i && (addr == ADDR_FREEZE);

  always_comb begin
    cfg_d    = cfg_q;
    freeze_d = freeze_q;
    if (cfg_en) cfg_d    = cfg_t'(wdata_i);
    if (frz_en) freeze_d = wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= CFG_RESET;
      freeze_q <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      freeze_q <= freeze_d;
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_COUNT:  rdata_o = RD_W'(count_i);
      ADDR_CFG:    rdata_o = RD_W'(cfg_q);
      ADDR_FREEZE: rdata_o = RD_W'(freeze_q);
      default:     rdata_o = '0;
    endcase
  end

  assign cfg_o    = cfg_q;
  assign freeze_o = freeze_q;
  assign cfg_wr_o = cfg_en;
endmodule

// File: rtl/usec_frac_prescaler.sv
module usec_frac_prescaler
  import usec_pkg::*;
#(
  parameter int ACC_W = FIELD_W + 2
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  cfg_t             cfg_i,
  output logic             tick_next_o,
  output logic             tick_o,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] dividend, divisor, sum, rem;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             hit, tick_q, tick_d;

  assign dividend = ACC_W'(cfg_i.mul_m1) + ACC_W'(1);
  assign divisor  = ACC_W'(cfg_i.div_m1) + ACC_W'(1);
  assign sum      = acc_q + dividend;
  assign hit      = (sum >= divisor);
  assign rem      = sum - divisor;

  always_comb begin
    acc_d  = sum;
    tick_d = 1'b0;
    if (clear_i) begin
      acc_d = '0;
    end else if (hit) begin
      tick_d = 1'b1;
      acc_d  = (rem >= divisor) ? '0 : rem;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign tick_next_o = tick_d;
  assign tick_o      = tick_q;
  assign acc_o       = acc_q;
endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
  parameter int COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               freeze_i,
  output logic [COUNT_W-1:0] count_o
);
  logic [COUNT_W-1:0] count_q, count_d;
  logic               cnt_en;

  assign cnt_en = tick_i && !freeze_i;

  always_comb begin
    count_d = count_q;
    if (cnt_en) count_d = count_q + COUNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_d;
  end

  assign count_o = count_q;
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
  import usec_pkg::*;
#(
  parameter int COUNT_W = 32,
  localparam int RD_W   = (COUNT_W > CFG_W) ? COUNT_W : CFG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CFG_W-1:0] reg_wdata,
  output logic [RD_W-1:0]  reg_rdata,
  output logic             tick_o
);
  localparam int ACC_W = FIELD_W + 2;

  logic               rst_sync_n;
  cfg_t               cfg_word;
  logic               freeze_q;
  logic               cfg_wr;
  logic               tick_next;
  logic [ACC_W-1:0]   acc_val;
  logic [COUNT_W-1:0] count_val;

  usec_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  usec_regs #(.COUNT_W(COUNT_W), .RD_W(RD_W)) u_regs (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .wr_i     (reg_wr),
    .addr_i   (reg_addr),
    .wdata_i  (reg_wdata),
    .count_i  (count_val),
    .cfg_o    (cfg_word),
    .freeze_o (freeze_q),
    .cfg_wr_o (cfg_wr),
    .rdata_o  (reg_rdata)
  );

  usec_frac_prescaler #(.ACC_W(ACC_W)) u_presc (
    .clk         (clk),
    .rst_ni      (rst_sync_n),
    .clear_i     (cfg_wr),
    .cfg_i       (cfg_word),
    .tick_next_o (tick_next),
    .tick_o      (tick_o),
    .acc_o       (acc_val)
  );

  usec_counter #(.COUNT_W(COUNT_W)) u_cnt (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .tick_i   (tick_next),
    .freeze_i (freeze_q),
    .count_o  (count_val)
  );
endmodule

// File: rtl/usec_timebase_chk.sv
module usec_timebase_chk #(
  parameter int COUNT_W = 32,
  parameter int ACC_W   = 10
) (
  input logic               clk,
  input logic               rst_ni,
  input logic               cfg_wr,
  input logic [15:0]        cfg_q,
  input logic [15:0]        wdata,
  input logic               freeze_q,
  input logic [ACC_W-1:0]   acc_q,
  input logic               tick_o,
  input logic [COUNT_W-1:0] count_q
);
  a_r4_count_follows_tick: assert property (@(posedge clk) disable iff (!rst_ni)
    !freeze_q |=> ((count_q - $past(count_q)) == COUNT_W'(tick_o)));

  a_r5_freeze_holds: assert property (@(posedge clk) disable iff (!rst_ni)
    freeze_q |=> $stable(count_q));

  a_r7_cfg_write_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    cfg_wr |=> (!tick_o && (acc_q == '0)));

  a_r6_cfg_stored: assert property (@(posedge clk) disable iff (!rst_ni)
    cfg_wr |=> (cfg_q == $past(wdata)));

  a_r2_acc_below_divisor: assert property (@(posedge clk) disable iff (!rst_ni)
    acc_q < (ACC_W'(cfg_q[7:0]) + ACC_W'(1)));

  a_r3_fast_ratio_every_cycle: assert property (@(posedge clk) disable iff (!rst_ni)
    ((cfg_q[15:8] >= cfg_q[7:0]) && !cfg_wr) |=> tick_o);
endmodule

bind usec_timebase usec_timebase_chk #(.COUNT_W(COUNT_W), .ACC_W(ACC_W)) u_chk (
  .clk      (clk),
  .rst_ni   (rst_sync_n),
  .cfg_wr   (cfg_wr),
  .cfg_q    (cfg_word),
  .wdata    (reg_wdata),
  .freeze_q (freeze_q),
  .acc_q    (acc_val),
  .tick_o   (tick_o),
  .count_q  (count_val)
);

// File: tb/usec_timebase_tb.sv
module usec_timebase_tb;
  localparam int CW = 12;
  localparam int RW = 16;

  logic          clk;
  logic          rst_n;
  logic          reg_wr;
  logic [1:0]    reg_addr;
  logic [15:0]   reg_wdata;
  logic [RW-1:0] reg_rdata;
  logic          tick_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  usec_timebase #(.COUNT_W(CW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tick_o    (tick_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  function automatic bit exp_tick(input int d, input int v, input int n);
    if (d >= v) return 1'b1;
    return ((n * d) / v) != (((n - 1) * d) / v);
  endfunction

  // writes a word, then compares tick_o for n cycles against the formula
  task automatic run_pattern(input logic [15:0] w, input int n,
                             output int errs, output int ticks, output int cdelta);
    int d, v, c0, c1;
    d = int'(w[15:8]) + 1;
    v = int'(w[7:0]) + 1;
    errs = 0;
    ticks = 0;
    do_write(2'd1, w);
    do_read(2'd0, c0);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (tick_o !== exp_tick(d, v, k)) errs++;
      if (tick_o === 1'b1) ticks++;
    end
    do_read(2'd0, c1);
    cdelta = (c1 - c0) & ((1 << CW) - 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int v, e, t, cd, c0, c1;
    logic [15:0] words [7];
    words = '{16'h000B, 16'h000C, 16'h0453, 16'h045F, 16'h04BF, 16'h0019, 16'h002F};
    rst_n = 1'b0;
    reg_wr = 1'b0;
    reg_addr = 2'd0;
    reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    do_read(2'd0, v); check(v == 0, "R1 count", v, 0);
    do_read(2'd1, v); check(v == 16'h000B, "R1 cfg", v, 16'h000B);
    do_read(2'd2, v); check(v == 0, "R1 freeze", v, 0);
    check(tick_o == 1'b0, "R1 tick", tick_o, 0);
    t = 0;
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      if (tick_o) t++;
    end
    check(t == 10, "R1 reset ratio ticks in 120", t, 10);

    // R8 spare address reads zero
    do_read(2'd3, v); check(v == 0, "R8 spare read", v, 0);

    // R9 standard words
    foreach (words[i]) begin
      run_pattern(words[i], 2 * (int'(words[i][7:0]) + 1), e, t, cd);
      check(e == 0, "R9 pattern", e, 0);
      check(t == 2 * (int'(words[i][15:8]) + 1), "R9 tick count", t,
            2 * (int'(words[i][15:8]) + 1));
    end

    // R2 / R3 / R4 sweep over small dividends and divisors
    for (int dm = 0; dm < 8; dm++) begin
      for (int vm = 0; vm < 24; vm++) begin
        run_pattern({dm[7:0], vm[7:0]}, 2 * (vm + 1) + 3, e, t, cd);
        if (dm >= vm) check(e == 0, "R3 every-cycle pattern", e, 0);
        else          check(e == 0, "R2 spread pattern", e, 0);
        check(cd == t, "R4 count delta", cd, t);
      end
    end

    // R6 save and restore
    do_write(2'd1, 16'h045F);
    do_read(2'd1, v);
    check(v == 16'h045F, "R6 readback", v, 16'h045F);
    do_write(2'd1, 16'h0000);
    run_pattern(16'(v), 192, e, t, cd);
    do_read(2'd1, c0);
    check(c0 == 16'h045F, "R6 restored word", c0, 16'h045F);
    check(e == 0 && t == 10, "R6 restored pattern ticks", t, 10);

    // R7 write clears accumulator: ratio 1/3 then rewrite mid-window
    do_write(2'd1, 16'h0002);
    @(negedge clk);
    run_pattern(16'h0002, 9, e, t, cd);
    check(e == 0, "R7 clear realigns pattern", e, 0);

    // R5 freeze holds count, ticks continue
    do_write(2'd1, 16'h0000);
    do_write(2'd2, 16'h0001);
    do_read(2'd0, c0);
    t = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (tick_o) t++;
    end
    do_read(2'd0, c1);
    check(c1 == c0, "R5 frozen count", c1, c0);
    check(t == 20, "R5 ticks while frozen", t, 20);

    // R7 counter address write ignored (still frozen)
    do_write(2'd0, 16'h0ABC);
    do_read(2'd0, v);
    check(v == c0, "R7 counter write ignored", v, c0);
    do_read(2'd2, v);
    check(v == 1, "R5 freeze readback", v, 1);

    do_write(2'd2, 16'h0000);
    do_read(2'd0, c0);
    repeat (20) @(negedge clk);
    do_read(2'd0, c1);
    check(c1 == ((c0 + 20) & 12'hFFF), "R5 unfreeze resumes", c1, (c0 + 20) & 12'hFFF);

    // R4 wrap of the counter
    do_read(2'd0, c0);
    repeat (4100) @(negedge clk);
    do_read(2'd0, c1);
    check(c1 == ((c0 + 4100) & 12'hFFF), "R4 wrap", c1, (c0 + 4100) & 12'hFFF);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule